// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single 16-bit down-counting timer channel with a byte-wide register interface. Software loads a start value as two bytes, low byte first. It picks one of three counting behaviours with a configuration request:

- a one-shot that raises its output at terminal count;
- a periodic rate generator that emits a one-clock pulse;
- a periodic square wave.

The counter does not advance on every clock. It moves one step on each cycle where `tick_en` is high. The system supplies that strobe at the timer input rate, nominally about 1.19 MHz.

The live count can be read at any time as two bytes, low byte first. A latch command freezes a snapshot of the count. That snapshot is returned by the following read pair, and reading its high byte releases it. Writing only the low byte stops the channel. The new value takes effect on the high-byte write. In the periodic modes the channel fires on count 1, so the period in ticks is one less than the written value.

Configuration requests are checked. Only the paired two-byte access code with binary counting is legal, and only the three supported mode codes are accepted. Anything else sets a sticky error flag and leaves the channel's mode as it was.

Top module: `interval_timer_chan`

## Requirements
- R1: Byte writes alternate low byte then high byte. The high-byte write loads the 16-bit value {second byte, first byte} into the channel.
- R2: A low-byte write stops any countdown and drives `timer_out` low from the next cycle. The live count then holds its value, however many ticks arrive, until the high byte is written.
- R3: In one-shot mode (`cfg_mode` = 3'b000), after loading N >= 1 the output rises in the cycle after the N-th tick and stays high until the next low-byte write. N = 0 leaves the channel idle with the output low.
- R4: In rate mode (`cfg_mode` = 3'b010), after loading N >= 2 the output is a one-clock pulse after every (N-1)-th tick, repeating indefinitely. N < 2 leaves the channel idle.
- R5: In square mode (`cfg_mode` = 3'b011), after loading N >= 2 the output starts low and inverts after every (N-1)-th tick, repeating indefinitely. N < 2 leaves the channel idle.
- R6: Byte reads alternate low byte then high byte of the live count. `rd_data` shows the byte in the cycle after `rd_en`.
- R7: A latch command copies the live count into a holding register and points the read toggle at the low byte, but only when no latch is pending. A latch command that arrives while one is pending is ignored. Reads return the held value until its high byte is read, which releases the latch.
- R8: A configuration request is legal only with `cfg_access` = 2'b11, `cfg_bcd` = 0 and one of the three mode codes above. An illegal request sets `cfg_err`, which stays set until reset, and leaves the mode unchanged.
- R9: A legal configuration request returns both byte toggles to the low byte and drops any pending latch.
- R10: The live count changes only on a tick or a high-byte write, and each tick while running lowers it by one. A one-shot that has expired and an idle load both read 0. In the periodic modes the count reloads to N-1 when it reaches 1. After reset the output is low, the error flag is clear, the count is 0 and the mode is one-shot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count-enable strobe at the timer input rate |
| cfg_we | input | 1 | Configuration request strobe |
| cfg_mode | input | 3 | Requested mode code |
| cfg_access | input | 2 | Requested byte-access code (only 2'b11 legal) |
| cfg_bcd | input | 1 | Requested decimal counting (only 0 legal) |
| latch_req | input | 1 | Count latch command |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write data |
| rd_en | input | 1 | Byte read strobe |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| timer_out | output | 1 | Channel output |
| cfg_err | output | 1 | Sticky flag for a rejected configuration request |

## Verification
The assertions take for granted that at most one of `cfg_we`, `latch_req`, `wr_en` and `rd_en` is high in a cycle. The design resolves a collision by giving configuration priority over latch, latch over write, and write over read, but the properties are written for one command per cycle. The bench issues every command through tasks that raise a single strobe for exactly one clock. It applies ticks as single-cycle pulses separated by an idle cycle, so a rate-mode pulse can always be seen returning low between ticks.

// File: rtl/itc_pkg.sv
package itc_pkg;

    typedef enum logic [1:0] {
        TMR_ONESHOT = 2'd0,
        TMR_RATE    = 2'd1,
        TMR_SQUARE  = 2'd2
    } tmr_mode_e;

    localparam logic [2:0] SEL_ONESHOT = 3'b000;
    localparam logic [2:0] SEL_RATE    = 3'b010;
    localparam logic [2:0] SEL_SQUARE  = 3'b011;
    localparam logic [1:0] ACC_PAIR    = 2'b11;

    typedef struct packed {
        logic      ok;
        tmr_mode_e mode;
    } mode_dec_t;

    function automatic mode_dec_t decode_req(input logic [2:0] sel,
                                             input logic [1:0] acc,
                                             input logic       bcd);
        mode_dec_t r;
        r.ok   = (acc == ACC_PAIR) && !bcd;
        r.mode = TMR_ONESHOT;
        case (sel)
            SEL_ONESHOT: r.mode = TMR_ONESHOT;
            SEL_RATE:    r.mode = TMR_RATE;
            SEL_SQUARE:  r.mode = TMR_SQUARE;
            default:     r.ok   = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/itc_config.sv
module itc_config
    import itc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_we,
    input  logic [2:0]   cfg_mode,
    input  logic [1:0]   cfg_access,
    input  logic         cfg_bcd,
    output tmr_mode_e    mode_o,
    output logic         err_o,
    output logic         cfg_ok_o
);

    typedef struct packed {
        tmr_mode_e mode;
        logic      err;
    } cfg_st_t;

    cfg_st_t   st_d, st_q;
    mode_dec_t dec;

    always_comb begin
        st_d     = st_q;
        cfg_ok_o = 1'b0;
        dec      = decode_req(cfg_mode, cfg_access, cfg_bcd);
        if (cfg_we) begin
            if (dec.ok) begin
                st_d.mode = dec.mode;
                cfg_ok_o  = 1'b1;
            end else begin
                st_d.err  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= TMR_ONESHOT;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign err_o  = st_q.err;

endmodule

// File: rtl/itc_byteport.sv
module itc_byteport #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_ok,
    input  logic                latch_req,
    input  logic                wr_en,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic [2*BYTE_W-1:0] live_cnt,
    output logic [BYTE_W-1:0]   rd_data_o,
    output logic                halt_o,
    output logic                load_o,
    output logic [2*BYTE_W-1:0] load_val_o,
    output logic                wr_hi_o,
    output logic                pend_o,
    output logic [2*BYTE_W-1:0] hold_o
);

    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic              wr_hi;
        logic              rd_hi;
        logic              pend;
        logic [CNT_W-1:0]  hold;
        logic [BYTE_W-1:0] lo_stage;
        logic [BYTE_W-1:0] rd_data;
    } port_st_t;

    port_st_t         st_d, st_q;
    logic [CNT_W-1:0] rd_src;

    always_comb begin
        st_d       = st_q;
        halt_o     = 1'b0;
        load_o     = 1'b0;
        load_val_o = {wr_data, st_q.lo_stage};
        rd_src     = st_q.pend ? st_q.hold : live_cnt;
        if (cfg_ok) begin
            st_d.wr_hi = 1'b0;
            st_d.rd_hi = 1'b0;
            st_d.pend  = 1'b0;
        end else if (latch_req) begin
            if (!st_q.pend) begin
                st_d.pend  = 1'b1;
                st_d.hold  = live_cnt;
                st_d.rd_hi = 1'b0;
            end
        end else if (wr_en) begin
            if (!st_q.wr_hi) begin
                st_d.lo_stage = wr_data;
                st_d.wr_hi    = 1'b1;
                halt_o        = 1'b1;
            end else begin
                st_d.wr_hi    = 1'b0;
                load_o        = 1'b1;
            end
        end else if (rd_en) begin
            if (st_q.rd_hi) begin
                st_d.rd_data = rd_src[CNT_W-1:BYTE_W];
                st_d.pend    = 1'b0;
            end else begin
                st_d.rd_data = rd_src[BYTE_W-1:0];
            end
            st_d.rd_hi = !st_q.rd_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.rd_data;
    assign wr_hi_o   = st_q.wr_hi;
    assign pend_o    = st_q.pend;
    assign hold_o    = st_q.hold;

endmodule

// File: rtl/itc_counter.sv
module itc_counter
    import itc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  tmr_mode_e        mode,
    input  logic             halt,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] live_o,
    output logic             out_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] period;
        logic             run;
        logic             out;
    } ctr_st_t;

    ctr_st_t          st_d, st_q;
    logic             armed;
    logic [CNT_W-1:0] per;

    always_comb begin
        st_d  = st_q;
        armed = 1'b0;
        per   = load_val;
        if (load) begin
            if (mode == TMR_ONESHOT) begin
                armed = (load_val != '0);
                per   = load_val;
            end else begin
                armed = (load_val > ONE);
                per   = load_val - ONE;
            end
            st_d.period = armed ? per : '0;
            st_d.cnt    = armed ? per : '0;
            st_d.run    = armed;
            st_d.out    = 1'b0;
        end else if (halt) begin
            st_d.run = 1'b0;
            st_d.out = 1'b0;
        end else begin
            if (mode == TMR_RATE) begin
                st_d.out = 1'b0;
            end
            if (tick_en && st_q.run) begin
                if (st_q.cnt == ONE) begin
                    case (mode)
                        TMR_ONESHOT: begin
                            st_d.out = 1'b1;
                            st_d.run = 1'b0;
                            st_d.cnt = '0;
                        end
                        TMR_RATE: begin
                            st_d.out = 1'b1;
                            st_d.cnt = st_q.period;
                        end
                        default: begin
                            st_d.out = !st_q.out;
                            st_d.cnt = st_q.period;
                        end
                    endcase
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign live_o = st_q.cnt;
    assign out_o  = st_q.out;

endmodule

// File: rtl/interval_timer_chan.sv
module interval_timer_chan
    import itc_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_mode,
    input  logic [1:0]        cfg_access,
    input  logic              cfg_bcd,
    input  logic              latch_req,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic              timer_out,
    output logic              cfg_err
);

    localparam int CNT_W = 2 * BYTE_W;

    tmr_mode_e        mode_w;
    logic             cfg_ok_w;
    logic             halt_w;
    logic             load_w;
    logic [CNT_W-1:0] load_val_w;
    logic [CNT_W-1:0] live_w;
    logic             wr_hi_w;
    logic             pend_w;
    logic [CNT_W-1:0] hold_w;

    itc_config u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_mode   (cfg_mode),
        .cfg_access (cfg_access),
        .cfg_bcd    (cfg_bcd),
        .mode_o     (mode_w),
        .err_o      (cfg_err),
        .cfg_ok_o   (cfg_ok_w)
    );

    itc_byteport #(.BYTE_W(BYTE_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_ok     (cfg_ok_w),
        .latch_req  (latch_req),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .live_cnt   (live_w),
        .rd_data_o  (rd_data),
        .halt_o     (halt_w),
        .load_o     (load_w),
        .load_val_o (load_val_w),
        .wr_hi_o    (wr_hi_w),
        .pend_o     (pend_w),
        .hold_o     (hold_w)
    );

    itc_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .mode     (mode_w),
        .halt     (halt_w),
        .load     (load_w),
        .load_val (load_val_w),
        .live_o   (live_w),
        .out_o    (timer_out)
    );

endmodule

// File: rtl/itc_checker.sv
module itc_checker
    import itc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             cfg_we,
    input logic             latch_req,
    input logic             wr_en,
    input logic             rd_en,
    input logic             timer_out,
    input logic             cfg_err,
    input tmr_mode_e        mode,
    input logic             wr_hi,
    input logic             pend,
    input logic [CNT_W-1:0] hold,
    input logic [CNT_W-1:0] live
);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R3
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TMR_ONESHOT && timer_out && !wr_en && !cfg_we) |=> timer_out);

    // R2
    lo_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi && !cfg_we && !latch_req) |=> !timer_out);

    // R4
    rise_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timer_out) |-> $past(tick_en));

    // R10
    count_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_en) |=> $stable(live));

    // R7
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !cfg_we && !rd_en) |=> $stable(hold));

    // R7
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !cfg_we && !rd_en) |=> pend);

endmodule

bind interval_timer_chan itc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .cfg_we    (cfg_we),
    .latch_req (latch_req),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .timer_out (timer_out),
    .cfg_err   (cfg_err),
    .mode      (mode_w),
    .wr_hi     (wr_hi_w),
    .pend      (pend_w),
    .hold      (hold_w),
    .live      (live_w)
);

// File: tb/interval_timer_chan_bench.sv
`timescale 1ns/1ps
module interval_timer_chan_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_mode = 3'b000;
    logic [1:0] cfg_access = 2'b11;
    logic       cfg_bcd = 1'b0;
    logic       latch_req = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       timer_out;
    logic       cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    interval_timer_chan u_interval_timer_chan (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_we(cfg_we),
        .cfg_mode(cfg_mode), .cfg_access(cfg_access), .cfg_bcd(cfg_bcd),
        .latch_req(latch_req), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .timer_out(timer_out),
        .cfg_err(cfg_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_cfg(input logic [2:0] m, input logic [1:0] a, input logic b);
        cfg_mode = m; cfg_access = a; cfg_bcd = b; cfg_we = 1'b1;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic do_wr(input logic [7:0] v);
        wr_data = v; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic do_rd(output logic [7:0] v);
        rd_en = 1'b1;
        step();
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic do_latch();
        latch_req = 1'b1;
        step();
        latch_req = 1'b0;
    endtask

    task automatic load16(input logic [15:0] v);
        do_wr(v[7:0]);
        do_wr(v[15:8]);
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        do_rd(lo);
        do_rd(hi);
        v = {hi, lo};
    endtask

    // one tick pulse; o = output just after the tick, g = output after the idle gap
    task automatic tick(output logic o, output logic g);
        tick_en = 1'b1;
        step();
        o = timer_out;
        tick_en = 1'b0;
        step();
        g = timer_out;
    endtask

    task automatic ticks(input int n);
        logic o, g;
        for (int i = 0; i < n; i++) tick(o, g);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v16;
        logic [7:0]  b;
        logic        o, g;

        repeat (3) step();
        rst_n = 1'b1;
        step();

        // Reset state
        check("R10 reset timer_out", int'(timer_out), 0);
        check("R10 reset cfg_err", int'(cfg_err), 0);
        rd16(v16);
        check("R10 R6 reset count", int'(v16), 0);

        // One-shot sweep
        for (int n = 0; n <= 6; n++) begin
            do_cfg(3'b000, 2'b11, 1'b0);
            load16(16'(n));
            check("R3 out low after load", int'(timer_out), 0);
            for (int k = 1; k <= 8; k++) begin
                tick(o, g);
                check("R3 one-shot out", int'(o), (n != 0 && k >= n) ? 1 : 0);
            end
            rd16(v16);
            check("R10 one-shot count after run", int'(v16), 0);
        end

        // Rate sweep
        for (int n = 0; n <= 5; n++) begin
            do_cfg(3'b010, 2'b11, 1'b0);
            load16(16'(n));
            for (int k = 1; k <= 12; k++) begin
                tick(o, g);
                check("R4 rate pulse", int'(o), (n >= 2 && (k % (n - 1)) == 0) ? 1 : 0);
                check("R4 rate pulse width", int'(g), 0);
            end
        end

        // Square sweep
        for (int n = 0; n <= 5; n++) begin
            do_cfg(3'b011, 2'b11, 1'b0);
            load16(16'(n));
            for (int k = 1; k <= 12; k++) begin
                tick(o, g);
                check("R5 square level", int'(o), (n >= 2) ? ((k / (n - 1)) % 2) : 0);
            end
        end

        // Periodic reload value on the live count
        do_cfg(3'b010, 2'b11, 1'b0);
        load16(16'd5);
        rd16(v16);
        check("R10 periodic loads N-1", int'(v16), 4);
        ticks(3);
        rd16(v16);
        check("R10 periodic count", int'(v16), 1);
        ticks(1);
        rd16(v16);
        check("R10 periodic reload", int'(v16), 4);

        // Two-byte load and live reads
        do_cfg(3'b000, 2'b11, 1'b0);
        load16(16'h1A05);
        do_rd(b);
        check("R6 R1 low byte", int'(b), 8'h05);
        do_rd(b);
        check("R6 R1 high byte", int'(b), 8'h1A);
        ticks(3);
        rd16(v16);
        check("R10 count after 3 ticks", int'(v16), 16'h1A02);

        // Latch
        do_latch();
        ticks(2);
        do_rd(b);
        check("R7 latched low", int'(b), 8'h02);
        do_rd(b);
        check("R7 latched high", int'(b), 8'h1A);
        rd16(v16);
        check("R7 released to live", int'(v16), 16'h1A00);
        do_latch();
        ticks(1);
        do_latch();
        rd16(v16);
        check("R7 second latch ignored", int'(v16), 16'h1A00);
        rd16(v16);
        check("R7 live after release", int'(v16), 16'h19FF);
        ticks(1);
        do_rd(b);
        check("R6 live low", int'(b), 8'hFE);
        do_latch();
        ticks(1);
        do_rd(b);
        check("R7 latch resets read toggle", int'(b), 8'hFE);
        do_rd(b);
        check("R7 latch high after toggle reset", int'(b), 8'h19);

        // Low-byte write halts
        do_cfg(3'b000, 2'b11, 1'b0);
        load16(16'd5);
        ticks(2);
        do_wr(8'h09);
        check("R2 out low after low write", int'(timer_out), 0);
        ticks(6);
        check("R2 stays halted", int'(timer_out), 0);
        rd16(v16);
        check("R2 count frozen", int'(v16), 3);
        do_wr(8'h00);
        rd16(v16);
        check("R1 high write loads", int'(v16), 9);
        load16(16'd1);
        tick(o, g);
        check("R3 expired", int'(o), 1);
        do_wr(8'h07);
        check("R2 low write clears out", int'(timer_out), 0);
        do_wr(8'h00);
        rd16(v16);
        check("R1 reload after clear", int'(v16), 7);

        // Illegal configuration
        do_cfg(3'b010, 2'b11, 1'b0);
        check("R8 legal no error", int'(cfg_err), 0);
        do_cfg(3'b000, 2'b11, 1'b1);
        check("R8 decimal rejected", int'(cfg_err), 1);
        load16(16'd3);
        for (int k = 1; k <= 4; k++) begin
            tick(o, g);
            check("R8 mode kept as rate", int'(o), (k % 2 == 0) ? 1 : 0);
        end
        do_cfg(3'b001, 2'b11, 1'b0);
        do_cfg(3'b000, 2'b01, 1'b0);
        load16(16'd3);
        for (int k = 1; k <= 4; k++) begin
            tick(o, g);
            check("R8 mode kept after bad codes", int'(o), (k % 2 == 0) ? 1 : 0);
        end
        do_cfg(3'b000, 2'b11, 1'b0);
        check("R8 error sticky", int'(cfg_err), 1);

        // Configuration resets toggles and latch
        do_wr(8'h04);
        do_cfg(3'b000, 2'b11, 1'b0);
        do_wr(8'h03);
        do_wr(8'h02);
        rd16(v16);
        check("R9 write toggle reset", int'(v16), 16'h0203);
        do_rd(b);
        do_cfg(3'b000, 2'b11, 1'b0);
        do_rd(b);
        check("R9 read toggle reset", int'(b), 8'h03);
        do_rd(b);
        do_latch();
        ticks(1);
        do_cfg(3'b000, 2'b11, 1'b0);
        rd16(v16);
        check("R9 latch dropped", int'(v16), 16'h0202);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule